// File: doc/BRIEF.md
# Status-Flag ALU with Branch-Condition Evaluator

This block is the arithmetic and logic stage of a 16-bit microcontroller datapath. Each cycle it takes an operation code, a size select (byte or word), a source and a destination operand. Its result comes straight from these inputs and from the carry bit of its own status register. A 4-bit status register holds overflow, negative, zero and carry. When an operation is presented with `op_valid` high, that register takes the new flags at the next rising clock edge. The update touches only the flags that the operation's fixed mask selects. Every other flag keeps its old value.

The result always appears zero-extended to the full word. A separate output tells the register file whether the destination should be written. Compare and bit-test produce flags only, so this output is low for them. A branch-condition evaluator reads the registered flags and reports whether the selected jump condition holds. The sequencer can therefore decide a conditional jump on the cycle after the flag-setting operation.

Top module: `flag_alu_unit`

## Requirements
- R1: Add (op 1) forms dst+src. Add-with-carry (op 2) forms dst+src+C. C takes the carry out of the active size (bit 8 for byte, bit 16 for word). V is set when both operands have the same sign and the result's sign differs from it.
- R2: Subtract-with-carry (op 3), subtract (op 4) and compare (op 5) form dst + ~src + k. Here k is C for op 3 and 1 for ops 4 and 5. C takes the carry out of the active size. V is set when dst and src have different signs and the result's sign differs from dst.
- R3: With `byte_op`=1, every operation except ops 13 and 15 works on bits 7:0 only. Result bits 15:8 read zero. N is the top bit of the active size. Z is set when the masked result is zero.
- R4: Decimal add (op 6) adds dst, src and C as 2 BCD digits (byte) or 4 BCD digits (word), for operands whose digits are all 0..9. The result is re-encoded as BCD modulo 100 or 10000. C is set when the sum exceeds 99 or 9999. V keeps its previous value.
- R5: AND (op 11) and bit-test (op 7) give dst&src, with C = result non-zero and V = 0. XOR (op 10) gives dst^src, with C = result non-zero and V = both operands' sign bits set.
- R6: Rotate through carry (op 12) shifts dst right by one and puts the old C into the top bit of the active size. Arithmetic shift (op 14) shifts right and keeps the sign bit. Both put the old bit 0 into C and clear V.
- R7: Byte swap (op 13) exchanges bits 15:8 and 7:0 of dst and leaves every flag unchanged. Sign-extend (op 14+1 = op 15) copies bit 7 of dst into bits 15:8 and sets N and Z on the word, C = result non-zero and V = 0. Both ops always work on the whole word.
- R8: Move (op 0, result = src), bit-clear (op 8, dst&~src) and bit-set (op 9, dst|src) leave every flag unchanged.
- R9: `flags` is {V,N,Z,C} in bits 3..0. A synchronous reset clears it to 0. It changes only at a rising edge with `op_valid`=1, and then only in the bits that the operation updates.
- R10: `cond_true` follows `cond_code` against the registered flags: 0 Z=0, 1 Z=1, 2 C=0, 3 C=1, 4 N=1, 5 N==V, 6 N!=V, 7 always.
- R11: `dst_write` is 0 for compare (op 5) and bit-test (op 7), and 1 for every other operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Commit this operation's flags at the next edge |
| op_code | input | 4 | Operation select |
| byte_op | input | 1 | 1 = byte size, 0 = word size |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| cond_code | input | 3 | Jump condition select |
| result | output | 16 | Operation result, zero-extended |
| dst_write | output | 1 | Destination should be written |
| flags | output | 4 | Registered {V,N,Z,C} |
| cond_true | output | 1 | Selected jump condition holds |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 8-bit byte and 4-bit decimal digits. Both sizes of every operation are therefore reachable, including the carry out of bit 8 and out of bit 16. Decimal add is driven with valid digits at both widths, so a carry ripples through 2 or 4 decimal digits and the 99 and 9999 wrap limits get exercised. The status register is carried between operations. Carry-in chains, flags that an operation masks out, and every jump condition are each observed against a running flag model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int WORD_W_DEF  = 16;
    localparam int BYTE_W_DEF  = 8;
    localparam int DIGIT_W     = 4;

    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADDC = 4'd2,
        OP_SUBC = 4'd3,
        OP_SUB  = 4'd4,
        OP_CMP  = 4'd5,
        OP_DADD = 4'd6,
        OP_BIT  = 4'd7,
        OP_BIC  = 4'd8,
        OP_BIS  = 4'd9,
        OP_XOR  = 4'd10,
        OP_AND  = 4'd11,
        OP_RRC  = 4'd12,
        OP_SWPB = 4'd13,
        OP_RRA  = 4'd14,
        OP_SXT  = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        CC_NZ     = 3'd0,
        CC_ZERO   = 3'd1,
        CC_NOCY   = 3'd2,
        CC_CY     = 3'd3,
        CC_NEG    = 3'd4,
        CC_GE     = 3'd5,
        CC_LT     = 3'd6,
        CC_ALWAYS = 3'd7
    } cond_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } flags_t;

    // Which flags an operation is allowed to modify.
    function automatic flags_t flag_mask(alu_op_e op);
        case (op)
            OP_MOV, OP_BIC, OP_BIS, OP_SWPB: return flags_t'(4'b0000);
            OP_DADD:                         return flags_t'(4'b0111);
            default:                         return flags_t'(4'b1111);
        endcase
    endfunction

    function automatic logic writes_dst(alu_op_e op);
        return !(op == OP_CMP || op == OP_BIT);
    endfunction

endpackage

// File: rtl/alu_bcd_adder.sv
module alu_bcd_adder #(
    parameter int WORD_W = alu_pkg::WORD_W_DEF,
    parameter int BYTE_W = alu_pkg::BYTE_W_DEF
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              cin,
    input  logic              byte_op,
    output logic [WORD_W-1:0] sum,
    output logic              cout
);
    localparam int DW          = alu_pkg::DIGIT_W;
    localparam int DIGITS      = WORD_W / DW;
    localparam int BYTE_DIGITS = BYTE_W / DW;

    logic [DIGITS:0] chain;
    assign chain[0] = cin;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [DW:0] raw;
        logic        over;
        assign raw  = {1'b0, a[DW*g +: DW]} + {1'b0, b[DW*g +: DW]} + {{DW{1'b0}}, chain[g]};
        assign over = raw > (DW+1)'(9);
        assign sum[DW*g +: DW] = over ? DW'(raw - (DW+1)'(10)) : raw[DW-1:0];
        assign chain[g+1] = over;
    end

    assign cout = byte_op ? chain[BYTE_DIGITS] : chain[DIGITS];

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WORD_W = alu_pkg::WORD_W_DEF,
    parameter int BYTE_W = alu_pkg::BYTE_W_DEF
) (
    input  alu_op_e           op,
    input  logic              byte_op,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] dst,
    input  logic              cin,
    output logic [WORD_W-1:0] result,
    output logic              write_dst,
    output flags_t            flags_new,
    output flags_t            mask
);
    localparam int HI_W = WORD_W - BYTE_W;

    logic              eff_byte;
    logic [WORD_W-1:0] size_mask, sign_sel;
    logic [WORD_W-1:0] s_m, d_m, s_inv;
    logic [WORD_W-1:0] add_b;
    logic              add_c;
    logic [WORD_W:0]   sum_full;
    logic [WORD_W-1:0] sum_m;
    logic              add_cy, add_ov;
    logic [WORD_W-1:0] bcd_sum;
    logic              bcd_cy;
    logic              res_nz;

    assign eff_byte  = byte_op && !(op == OP_SWPB || op == OP_SXT);
    assign size_mask = eff_byte ? {{HI_W{1'b0}}, {BYTE_W{1'b1}}} : {WORD_W{1'b1}};
    assign sign_sel  = {{(WORD_W-1){1'b0}}, 1'b1} << (eff_byte ? BYTE_W-1 : WORD_W-1);
    assign s_m       = src & size_mask;
    assign d_m       = dst & size_mask;
    assign s_inv     = ~src & size_mask;

    // Shared binary adder: subtraction adds the inverted source.
    always_comb begin
        case (op)
            OP_ADDC:         begin add_b = s_m;   add_c = cin;  end
            OP_SUB, OP_CMP:  begin add_b = s_inv; add_c = 1'b1; end
            OP_SUBC:         begin add_b = s_inv; add_c = cin;  end
            default:         begin add_b = s_m;   add_c = 1'b0; end
        endcase
    end

    assign sum_full = {1'b0, d_m} + {1'b0, add_b} + {{WORD_W{1'b0}}, add_c};
    assign sum_m    = sum_full[WORD_W-1:0] & size_mask;
    assign add_cy   = eff_byte ? sum_full[BYTE_W] : sum_full[WORD_W];
    assign add_ov   = (((d_m & sign_sel) != 0) == ((add_b & sign_sel) != 0))
                   && (((sum_m & sign_sel) != 0) != ((d_m & sign_sel) != 0));

    alu_bcd_adder #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_bcd (
        .a       (d_m),
        .b       (s_m),
        .cin     (cin),
        .byte_op (eff_byte),
        .sum     (bcd_sum),
        .cout    (bcd_cy)
    );

    always_comb begin
        result        = '0;
        flags_new     = '0;
        case (op)
            OP_MOV:  result = s_m;
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                result      = sum_m;
                flags_new.c = add_cy;
                flags_new.v = add_ov;
            end
            OP_DADD: begin
                result      = bcd_sum & size_mask;
                flags_new.c = bcd_cy;
            end
            OP_AND, OP_BIT: result = d_m & s_m;
            OP_BIC:  result = d_m & ~s_m;
            OP_BIS:  result = d_m | s_m;
            OP_XOR: begin
                result      = d_m ^ s_m;
                flags_new.v = ((d_m & sign_sel) != 0) && ((s_m & sign_sel) != 0);
            end
            OP_RRC: begin
                result      = (d_m >> 1) | (cin ? sign_sel : '0);
                flags_new.c = d_m[0];
            end
            OP_RRA: begin
                result      = (d_m >> 1) | (d_m & sign_sel);
                flags_new.c = d_m[0];
            end
            OP_SWPB: result = {dst[BYTE_W-1:0], dst[WORD_W-1:BYTE_W]};
            OP_SXT:  result = {{HI_W{dst[BYTE_W-1]}}, dst[BYTE_W-1:0]};
            default: result = '0;
        endcase
        res_nz = (result != '0);
        if (op == OP_AND || op == OP_BIT || op == OP_XOR || op == OP_SXT)
            flags_new.c = res_nz;
        flags_new.n = (result & sign_sel) != '0;
        flags_new.z = !res_nz;
    end

    assign write_dst = writes_dst(op);
    assign mask      = flag_mask(op);

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_pkg::*;
(
    input  flags_t fl,
    input  cond_e  cc,
    output logic   taken
);
    always_comb begin
        case (cc)
            CC_NZ:     taken = !fl.z;
            CC_ZERO:   taken = fl.z;
            CC_NOCY:   taken = !fl.c;
            CC_CY:     taken = fl.c;
            CC_NEG:    taken = fl.n;
            CC_GE:     taken = (fl.n == fl.v);
            CC_LT:     taken = (fl.n != fl.v);
            default:   taken = 1'b1;
        endcase
    end
endmodule

// File: rtl/flag_alu_unit.sv
module flag_alu_unit
    import alu_pkg::*;
#(
    parameter int WORD_W = alu_pkg::WORD_W_DEF,
    parameter int BYTE_W = alu_pkg::BYTE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              byte_op,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] dst,
    input  logic [2:0]        cond_code,
    output logic [WORD_W-1:0] result,
    output logic              dst_write,
    output logic [3:0]        flags,
    output logic              cond_true
);
    alu_op_e op;
    flags_t  flags_q, flags_new, upd_mask;

    assign op = alu_op_e'(op_code);

    alu_core #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_core (
        .op        (op),
        .byte_op   (byte_op),
        .src       (src),
        .dst       (dst),
        .cin       (flags_q.c),
        .result    (result),
        .write_dst (dst_write),
        .flags_new (flags_new),
        .mask      (upd_mask)
    );

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (op_valid)
            flags_q <= (flags_q & ~upd_mask) | (flags_new & upd_mask);
    end

    alu_cond_eval u_cond (
        .fl    (flags_q),
        .cc    (cond_e'(cond_code)),
        .taken (cond_true)
    );

    assign flags = flags_q;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(flags_q)); // R9
    AST_NOFLAG_OPS: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op == OP_MOV || op == OP_BIC || op == OP_BIS || op == OP_SWPB)
        |=> $stable(flags_q)); // R8
    AST_DADD_V_KEEP: assert property (@(posedge clk) disable iff (rst)
        op_valid && op == OP_DADD |=> flags_q.v == $past(flags_q.v)); // R4
    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (rst)
        op_valid && (op == OP_ADD || op == OP_SUB || op == OP_AND || op == OP_XOR)
        |=> flags_q.z == ($past(result) == '0)); // R3
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
        byte_op && !(op == OP_SWPB || op == OP_SXT)
        |-> result[WORD_W-1:BYTE_W] == '0); // R3
    AST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CMP || op == OP_BIT) |-> !dst_write); // R11

endmodule

// File: tb/flag_alu_unit_test.sv
`timescale 1ns/1ps
module flag_alu_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic        byte_op;
    logic [15:0] src, dst;
    logic [2:0]  cond_code;
    logic [15:0] result;
    logic        dst_write;
    logic [3:0]  flags;
    logic        cond_true;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [3:0] mflags;  // model {V,N,Z,C}

    always #4 clk = ~clk;

    flag_alu_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .byte_op(byte_op), .src(src), .dst(dst), .cond_code(cond_code),
        .result(result), .dst_write(dst_write), .flags(flags), .cond_true(cond_true)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            1, 2:       return "R1";
            3, 4, 5:    return "R2";
            6:          return "R4";
            7, 10, 11:  return "R5";
            12, 14:     return "R6";
            13, 15:     return "R7";
            default:    return "R8";
        endcase
    endfunction

    function automatic int bcd2bin(input int v);
        return (v & 15) + ((v >> 4) & 15) * 10 + ((v >> 8) & 15) * 100 + ((v >> 12) & 15) * 1000;
    endfunction

    function automatic int bin2bcd(input int v);
        return (v % 10) | (((v / 10) % 10) << 4) | (((v / 100) % 10) << 8) | (((v / 1000) % 10) << 12);
    endfunction

    function automatic bit cond_ref(input logic [3:0] f, input int cc);
        case (cc)
            0: return !f[1];
            1: return f[1];
            2: return !f[0];
            3: return f[0];
            4: return f[2];
            5: return f[2] == f[3];
            6: return f[2] != f[3];
            default: return 1'b1;
        endcase
    endfunction

    task automatic model(input int op, input bit bo, input int s, input int d, input bit cin,
                         output int res, output bit wr, output logic [3:0] fl, output logic [3:0] mk);
        int w, m, sb, sm, dm, t, lim, bin;
        bit c, v;
        w  = (bo && op != 13 && op != 15) ? 8 : 16;
        m  = (1 << w) - 1;
        sb = 1 << (w - 1);
        sm = s & m;
        dm = d & m;
        c = 0; v = 0; wr = 1; mk = 4'b1111; res = 0;
        case (op)
            0: begin res = sm; mk = 4'b0000; end
            1, 2: begin
                t = dm + sm + ((op == 2) ? int'(cin) : 0);
                res = t & m; c = ((t >> w) & 1) != 0;
                v = (((dm & sb) != 0) == ((sm & sb) != 0)) && (((res & sb) != 0) != ((dm & sb) != 0));
            end
            3, 4, 5: begin
                t = dm + ((~s) & m) + ((op == 3) ? int'(cin) : 1);
                res = t & m; c = ((t >> w) & 1) != 0;
                v = (((dm & sb) != 0) != ((sm & sb) != 0)) && (((res & sb) != 0) != ((dm & sb) != 0));
                wr = (op != 5);
            end
            6: begin
                lim = (w == 8) ? 99 : 9999;
                bin = bcd2bin(dm) + bcd2bin(sm) + int'(cin);
                c = bin > lim;
                res = bin2bcd(bin % (lim + 1));
                mk = 4'b0111;
            end
            7, 11: begin res = dm & sm; c = res != 0; wr = (op != 7); end
            8: begin res = dm & ~sm & m; mk = 4'b0000; end
            9: begin res = dm | sm; mk = 4'b0000; end
            10: begin res = dm ^ sm; c = res != 0; v = ((dm & sb) != 0) && ((sm & sb) != 0); end
            12: begin res = (dm >> 1) | (cin ? sb : 0); c = dm[0]; end
            14: begin res = (dm >> 1) | (dm & sb); c = dm[0]; end
            13: begin res = ((d & 255) << 8) | ((d >> 8) & 255); mk = 4'b0000; end
            default: begin res = (((d & 128) != 0) ? 32'hFF00 : 0) | (d & 255); c = res != 0; end
        endcase
        fl = {v, (res & sb) != 0, res == 0, c};
    endtask

    task automatic step(input int op, input bit bo, input int s, input int d,
                        input bit vld, input int cc);
        int eres; bit ewr; logic [3:0] efl, emk, nxt;
        @(negedge clk);
        op_code = 4'(op); byte_op = bo; src = 16'(s); dst = 16'(d);
        op_valid = vld; cond_code = 3'(cc);
        #1;
        model(op, bo, s & 16'hFFFF, d & 16'hFFFF, mflags[0], eres, ewr, efl, emk);
        check(result == 16'(eres), req_of(op), "result", int'(result), eres);
        check(dst_write == ewr, "R11", "dst_write", int'(dst_write), int'(ewr));
        check(cond_true == cond_ref(mflags, cc), "R10", "cond_true", int'(cond_true),
              int'(cond_ref(mflags, cc)));
        if (bo && op != 13 && op != 15)
            check(result[15:8] == 8'h00, "R3", "upper byte", int'(result[15:8]), 0);
        nxt = vld ? ((mflags & ~emk) | (efl & emk)) : mflags;
        @(posedge clk);
        #1;
        check(flags == nxt, vld ? req_of(op) : "R9", "flags", int'(flags), int'(nxt));
        mflags = nxt;
    endtask

    function automatic int rand_bcd();
        int v = 0;
        for (int i = 0; i < 4; i++) v |= ($urandom % 10) << (4 * i);
        return v;
    endfunction

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240613));
        rst = 1'b1; op_valid = 0; op_code = 0; byte_op = 0; src = 0; dst = 0; cond_code = 0;
        mflags = 4'b0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(flags == 4'b0000, "R9", "reset flags", int'(flags), 0);

        // Directed corners
        step(1, 0, 16'h0001, 16'h7FFF, 1, 4);   // R1 signed overflow
        step(1, 1, 16'h0001, 16'h00FF, 1, 5);   // R1 byte carry, R3 zero
        step(2, 0, 16'h0000, 16'hFFFF, 1, 3);   // R1 carry-in ripple
        step(4, 0, 16'h1234, 16'h1234, 1, 1);   // R2 equal -> Z, C
        step(4, 0, 16'h0001, 16'h0000, 1, 2);   // R2 borrow -> C clear
        step(3, 1, 16'h0080, 16'h007F, 1, 6);   // R2 byte overflow
        step(5, 0, 16'h8000, 16'h7FFF, 1, 6);   // R2 compare, R11
        step(6, 0, 16'h0001, 16'h9999, 1, 3);   // R4 word wrap
        step(6, 1, 16'h0001, 16'h0099, 1, 3);   // R4 byte wrap with carry in
        step(10, 0, 16'h8001, 16'h8000, 1, 6);  // R5 XOR both signs
        step(7, 1, 16'h00F0, 16'h000F, 1, 0);   // R5 bit test zero
        step(12, 0, 16'h0003, 16'h0003, 1, 3);  // R6 rotate
        step(14, 1, 16'h0000, 16'h0081, 1, 4);  // R6 byte shift keeps sign
        step(15, 0, 16'h0000, 16'h1280, 1, 4);  // R7 sign extend
        step(13, 0, 16'h0000, 16'hA55A, 1, 7);  // R7 swap
        step(9, 0, 16'h0F0F, 16'hF000, 1, 0);   // R8 bit set
        step(1, 0, 16'h8000, 16'h8000, 0, 5);   // R9 idle: flags hold

        for (int i = 0; i < 3000; i++) begin
            int op = $urandom % 16;
            bit bo = $urandom % 2;
            int s = $urandom % 65536;
            int d = $urandom % 65536;
            bit vld = ($urandom % 10) != 0;
            int cc = $urandom % 8;
            if (op == 6) begin s = rand_bcd(); d = rand_bcd(); end
            step(op, bo, s, d, vld, cc);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule